// File: doc/BRIEF.md
# Radio Data Block Buffer with Status Readout

This block sits between the block decoder of a broadcast radio data receiver and a host serial link. Every received 16-bit data block arrives with its offset-word result, its corrected-bit count and the carrier identification flag. The buffer stores up to 24 such blocks in arrival order, together with the synchronization state at the moment each block arrived. The 10 check bits are never stored. The oldest unread block is always presented as a 32-bit readout word. That word starts with a fixed `1010` header and carries live occupancy flags, which tell the host whether more blocks follow and roughly how many remain.

A separate serial shifter consumes the presented word one bit per `bit_take` pulse while a read session (`rd_active`) is open. A word is retired once all 32 bits have gone out. A word is also retired if the session closes with only its final bit still outstanding. Any other interrupted word is presented again from its first bit. An empty buffer presents an all-zero word.

An active-low request line asks the host to read. It falls once the stored count reaches a selectable fill threshold. It is held high during a session, and for a fixed blanking interval after each session. After a synchronization reset it also stays high until synchronization has been seen again.

Top module: `rds_blkbuf`

## Requirements
- R1: A non-empty buffer presents its oldest block as `rd_word` = {4'b1010 in [31:28], offset-found in [27], offset kind in [26:24], more-flag in [23], fill code in [22:21], carrier-id flag in [20], stored sync flag in [19], error code in [18:16], data in [15:0]}.
- R2: The more-flag [23] is 1 exactly when 2 or more blocks are stored. The fill code [22:21] is 2'b00 for 1–7 stored blocks, 2'b01 for 8–15, 2'b10 for 16–23 and 2'b11 for 24.
- R3: Blocks are presented in arrival order, and at most 24 are kept. A write into a full buffer that is not retiring a word in the same cycle drops the oldest block, and the count stays at 24.
- R4: With no block stored, `rd_word` is all zero and `bit_take` pulses have no effect.
- R5: A word is retired by its 32nd `bit_take` within a session, or at the end of a session when exactly 31 of its bits were taken. A session that ends with fewer taken bits leaves the same word presented from its first bit.
- R6: A block with `blk_valid` is stored when `synced`=1, or when `wr_unsync_en`=1. It is never stored while `sync_rst`=1.
- R7: The stored sync flag is the value of `synced` in the cycle the block was written. Data, error code (including 3'b110, uncorrectable) and offset fields are stored and returned unchanged.
- R8: `req_n` is low when the stored count is at least the threshold picked by `thr_sel`: 2'b00→1, 2'b01→4, 2'b10→8, 2'b11→12, with no other condition holding it high.
- R9: `sync_rst` empties the buffer. From then on, `req_n` stays high until `synced`=1 has been seen outside `sync_rst`.
- R10: `req_n` is high while `rd_active`=1, and for `HOLD_CYC` cycles after the cycle in which a session ends.
- R11: After `rst_n` reset, `rd_word` is zero and `req_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_rst | input | 1 | Synchronization reset: clears buffer, gates request |
| synced | input | 1 | Current synchronization state of the receiver |
| wr_unsync_en | input | 1 | Also store blocks received while unsynchronized |
| thr_sel | input | 2 | Request fill threshold select |
| blk_valid | input | 1 | One-cycle strobe: a decoded block is offered |
| blk_ow_found | input | 1 | Offset word was detected for this block |
| blk_ow_kind | input | 3 | Offset word kind code |
| blk_ari | input | 1 | Carrier identification detected |
| blk_err | input | 3 | Corrected bit count 0–5, 3'b110 uncorrectable |
| blk_data | input | 16 | Block information bits |
| rd_active | input | 1 | Read session open |
| bit_take | input | 1 | Shifter consumed one bit of the presented word |
| rd_word | output | 32 | Presented readout word |
| req_n | output | 1 | Active-low read request |

## Verification
Every storage effect (write, retire, overwrite, clear) takes one clock edge, so `rd_word` and the more/fill flags change in the cycle after the strobe that causes them. `req_n` reacts within the same cycle to `rd_active`, and one edge later to count, blanking and sync-seen changes. The bench keeps a behavioural queue model that is stepped on each rising edge with the inputs present at that edge. All outputs are then compared at the following falling edge, against an expectation built from the model state and the inputs, which are held at that point. Directed checks with literal values cover the thresholds, the 31-bit retire rule, the overwrite of the oldest block and the post-reset request gating.

// File: rtl/rds_blkbuf_pkg.sv
package rds_blkbuf_pkg;

   localparam logic [3:0] WORD_HDR = 4'b1010;
   localparam int unsigned WORD_BITS = 32;

   typedef struct packed {
      logic        owd;
      logic [2:0]  kind;
      logic        ari;
      logic        syc;
      logic [2:0]  err;
      logic [15:0] data;
   } blk_entry_t;

   function automatic int unsigned thr_of(input logic [1:0] sel);
      case (sel)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 8;
         default: return 12;
      endcase
   endfunction

endpackage

// File: rtl/rbb_store.sv
module rbb_store
   import rds_blkbuf_pkg::*;
#(
   parameter int unsigned DEPTH = 24,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic             pop,
   input  blk_entry_t       din,
   output blk_entry_t       head,
   output logic [CNT_W-1:0] count,
   output logic             overwrite
);

   blk_entry_t       mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nx, rd_nx;
   logic             full, pop_ok;

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wr_nx = wr_ptr + PTR_W'(1);
         assign rd_nx = rd_ptr + PTR_W'(1);
      end else begin : g_mod
         assign wr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   assign full      = (count == CNT_W'(DEPTH));
   assign pop_ok    = pop && (count != '0);
   assign overwrite = push && full && !pop_ok;
   assign head      = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nx;
         if (pop_ok || overwrite) rd_ptr <= rd_nx;
         if (!overwrite)
            count <= count + {{(CNT_W-1){1'b0}}, push} - {{(CNT_W-1){1'b0}}, pop_ok};
      end
   end

   // R3: occupancy never exceeds capacity
   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)) else $error("count above depth");

   // R3: an overwrite leaves the buffer full
   p_overwrite_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (overwrite && !clr) |=> (count == CNT_W'(DEPTH))) else $error("overwrite lost fullness");

   // R9: a synchronization reset empties the buffer
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0)) else $error("clear did not empty");

endmodule

// File: rtl/rbb_reader.sv
module rbb_reader
   import rds_blkbuf_pkg::*;
#(
   parameter int unsigned WBITS = WORD_BITS,
   localparam int unsigned BC_W = $clog2(WBITS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic rd_active,
   input  logic bit_take,
   input  logic nonempty,
   input  logic overwrite,
   output logic pop,
   output logic sess_end
);

   logic [BC_W-1:0] bit_cnt;
   logic            rd_prev, last, taking;

   assign last     = (bit_cnt == BC_W'(WBITS - 1));
   assign sess_end = rd_prev && !rd_active;
   assign taking   = rd_active && bit_take && nonempty;
   assign pop      = nonempty && !clr && last && (taking || sess_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         rd_prev <= 1'b0;
      end else begin
         rd_prev <= rd_active;
         if (clr || sess_end || overwrite)
            bit_cnt <= '0;
         else if (taking)
            bit_cnt <= last ? '0 : bit_cnt + BC_W'(1);
      end
   end

   // R5: outside a session, and after its closing cycle, the word restarts at bit 0
   p_idle_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_active && !rd_prev) |-> (bit_cnt == '0)) else $error("bit position kept outside session");

endmodule

// File: rtl/rbb_request.sv
module rbb_request
   import rds_blkbuf_pkg::*;
#(
   parameter int unsigned CNT_W    = 5,
   parameter int unsigned HOLD_CYC = 40,
   localparam int unsigned HW      = $clog2(HOLD_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             synced,
   input  logic             sess_end,
   input  logic             rd_active,
   input  logic [1:0]       thr_sel,
   input  logic [CNT_W-1:0] count,
   output logic             req_n
);

   logic [HW-1:0] hold_cnt;
   logic          seen;
   logic          enough;

   assign enough = (count >= CNT_W'(thr_of(thr_sel)));
   assign req_n  = !(seen && !rd_active && (hold_cnt == '0) && enough);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt <= '0;
         seen     <= 1'b0;
      end else begin
         if (sess_end)
            hold_cnt <= HW'(HOLD_CYC);
         else if (hold_cnt != '0)
            hold_cnt <= hold_cnt - HW'(1);
         if (clr)
            seen <= 1'b0;
         else if (synced)
            seen <= 1'b1;
      end
   end

   // R10: the line stays high in the cycle after a session closes
   p_blank_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sess_end |=> req_n) else $error("request low right after session");

   // R10: no request while the blanking counter runs
   p_hold_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_cnt != '0) |-> req_n) else $error("request during blanking");

   // R9: after a synchronization reset the line stays high
   p_gate_after_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> req_n) else $error("request right after sync reset");

endmodule

// File: rtl/rds_blkbuf.sv
module rds_blkbuf
   import rds_blkbuf_pkg::*;
#(
   parameter int unsigned DEPTH    = 24,
   parameter int unsigned HOLD_CYC = 40,
   localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sync_rst,
   input  logic        synced,
   input  logic        wr_unsync_en,
   input  logic [1:0]  thr_sel,
   input  logic        blk_valid,
   input  logic        blk_ow_found,
   input  logic [2:0]  blk_ow_kind,
   input  logic        blk_ari,
   input  logic [2:0]  blk_err,
   input  logic [15:0] blk_data,
   input  logic        rd_active,
   input  logic        bit_take,
   output logic [31:0] rd_word,
   output logic        req_n
);

   generate
      if (DEPTH < 17 || DEPTH > 4096) begin : g_bad_depth
         $error("DEPTH must lie in 17..4096 for the fill code bands");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("HOLD_CYC must be at least 1");
      end
   endgenerate

   blk_entry_t       din, head;
   logic [CNT_W-1:0] count;
   logic             push, pop, overwrite, sess_end, nonempty;
   logic             more;
   logic [1:0]       fill;

   assign push     = blk_valid && !sync_rst && (synced || wr_unsync_en);
   assign nonempty = (count != '0);
   assign din      = '{owd: blk_ow_found, kind: blk_ow_kind, ari: blk_ari,
                       syc: synced, err: blk_err, data: blk_data};

   rbb_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(sync_rst), .push(push), .pop(pop),
      .din(din), .head(head), .count(count), .overwrite(overwrite)
   );

   rbb_reader #(.WBITS(WORD_BITS)) u_reader (
      .clk(clk), .rst_n(rst_n), .clr(sync_rst), .rd_active(rd_active),
      .bit_take(bit_take), .nonempty(nonempty), .overwrite(overwrite),
      .pop(pop), .sess_end(sess_end)
   );

   rbb_request #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_request (
      .clk(clk), .rst_n(rst_n), .clr(sync_rst), .synced(synced),
      .sess_end(sess_end), .rd_active(rd_active), .thr_sel(thr_sel),
      .count(count), .req_n(req_n)
   );

   always_comb begin
      more = (count >= CNT_W'(2));
      if (count == CNT_W'(DEPTH))      fill = 2'b11;
      else if (count >= CNT_W'(16))    fill = 2'b10;
      else if (count >= CNT_W'(8))     fill = 2'b01;
      else                             fill = 2'b00;
   end

   assign rd_word = nonempty ?
      {WORD_HDR, head.owd, head.kind, more, fill, head.ari, head.syc, head.err, head.data}
      : 32'h0;

   // R4: an empty buffer shows an all-zero word
   p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> (rd_word == 32'h0)) else $error("empty word not zero");

   // R5: a retire without a write lowers the count by one
   p_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !sync_rst) |=> ((count + CNT_W'(1)) == $past(count)))
      else $error("retire did not lower count");

   // R6: an unsynchronized block with storing disabled leaves the count alone
   p_unsync_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid && !synced && !wr_unsync_en && !sync_rst && !pop) |=> (count == $past(count)))
      else $error("unsynchronized block stored");

endmodule

// File: tb/tb_rds_blkbuf.sv
module tb_rds_blkbuf;

   localparam int HOLD = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_rst = 1'b0, synced = 1'b0, wr_unsync_en = 1'b0;
   logic [1:0]  thr_sel = 2'b00;
   logic        blk_valid = 1'b0, blk_ow_found = 1'b0, blk_ari = 1'b0;
   logic [2:0]  blk_ow_kind = 3'b000, blk_err = 3'b000;
   logic [15:0] blk_data = 16'h0;
   logic        rd_active = 1'b0, bit_take = 1'b0;
   logic [31:0] rd_word;
   logic        req_n;

   always #10 clk = ~clk;

   rds_blkbuf #(.DEPTH(24), .HOLD_CYC(HOLD)) dut (
      .clk(clk), .rst_n(rst_n), .sync_rst(sync_rst), .synced(synced),
      .wr_unsync_en(wr_unsync_en), .thr_sel(thr_sel), .blk_valid(blk_valid),
      .blk_ow_found(blk_ow_found), .blk_ow_kind(blk_ow_kind), .blk_ari(blk_ari),
      .blk_err(blk_err), .blk_data(blk_data), .rd_active(rd_active),
      .bit_take(bit_take), .rd_word(rd_word), .req_n(req_n)
   );

   int checks = 0, failures = 0;
   bit done = 1'b0;

   // behavioural reference state
   logic [24:0] q[$];
   int  bitc = 0, hold = 0;
   bit  seen = 0, rd_prev = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic int thr_val(input logic [1:0] s);
      return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : (s == 2'd2) ? 8 : 12;
   endfunction

   function automatic logic [31:0] exp_word();
      int n = q.size();
      logic [1:0] rf;
      if (n == 0) return 32'h0;
      rf = (n >= 24) ? 2'b11 : (n >= 16) ? 2'b10 : (n >= 8) ? 2'b01 : 2'b00;
      return {4'b1010, q[0][24:21], (n >= 2), rf, q[0][20:0]};
   endfunction

   function automatic logic exp_req();
      return !(seen && !rd_active && hold == 0 && q.size() >= thr_val(thr_sel));
   endfunction

   task automatic model_edge();
      bit fall = rd_prev && !rd_active;
      bit pop = 0;
      if (sync_rst) begin
         q.delete();
         bitc = 0;
         seen = 0;
      end else begin
         if (rd_active && bit_take && q.size() > 0) begin
            if (bitc == 31) begin pop = 1; bitc = 0; end
            else bitc++;
         end
         if (fall) begin
            if (bitc == 31 && q.size() > 0) pop = 1;
            bitc = 0;
         end
         if (pop) void'(q.pop_front());
         if (blk_valid && (synced || wr_unsync_en)) begin
            if (q.size() == 24) begin void'(q.pop_front()); bitc = 0; end
            q.push_back({blk_ow_found, blk_ow_kind, blk_ari, synced, blk_err, blk_data});
         end
         if (synced) seen = 1;
      end
      if (fall) hold = HOLD;
      else if (hold > 0) hold--;
      rd_prev = rd_active;
   endtask

   task automatic step();
      logic [31:0] ew;
      @(posedge clk);
      if (rst_n) model_edge();
      @(negedge clk);
      ew = exp_word();
      chk((q.size() == 0) ? "R4 word" : "R1 word", rd_word, ew);
      if (q.size() != 0) begin
         chk("R2 more/fill", {29'h0, rd_word[23:21]}, {29'h0, ew[23:21]});
         chk("R7 stored fields", {12'h0, rd_word[19:0]}, {12'h0, ew[19:0]});
      end
      chk(!seen ? "R9 req" : (hold != 0 || rd_active) ? "R10 req" : "R8 req",
          {31'h0, req_n}, {31'h0, exp_req()});
   endtask

   task automatic wr(input logic s, input logic en, input logic [15:0] d, input logic [2:0] e);
      synced = s; wr_unsync_en = en; blk_data = d; blk_err = e;
      blk_ow_found = d[0]; blk_ow_kind = d[3:1]; blk_ari = d[4];
      blk_valid = 1'b1;
      step();
      blk_valid = 1'b0;
   endtask

   task automatic rd(input int n);
      rd_active = 1'b1; bit_take = 1'b0;
      step();
      for (int i = 0; i < n; i++) begin
         bit_take = 1'b1;
         step();
      end
      bit_take = 1'b0; rd_active = 1'b0;
      step();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R11 reset word", rd_word, 32'h0);
      chk("R11 reset req", {31'h0, req_n}, 32'h1);
      rst_n = 1'b1;
      step();

      // R6: unsynchronized blocks dropped when storing is disabled
      for (int i = 0; i < 3; i++) wr(1'b0, 1'b0, 16'hDEAD, 3'b000);
      chk("R6 dropped", rd_word, 32'h0);

      // R7: sync flag and uncorrectable code kept
      wr(1'b1, 1'b0, 16'h1111, 3'b000);
      wr(1'b1, 1'b0, 16'h2222, 3'b110);
      wr(1'b0, 1'b1, 16'h3333, 3'b010);
      synced = 1'b1;

      // R5: interrupted reads
      rd(10);
      chk("R5 resume after 10", {16'h0, rd_word[15:0]}, 32'h1111);
      rd(31);
      chk("R5 retire at 31", {16'h0, rd_word[15:0]}, 32'h2222);
      chk("R7 uncorrectable kept", {28'h0, rd_word[19:16]}, 32'hE);
      rd(32);
      chk("R7 unsync flag stored", {12'h0, rd_word[19:0]}, {12'h0, 4'b0010, 16'h3333});
      rd(32);
      chk("R4 empty after drain", rd_word, 32'h0);
      rd(5);
      chk("R4 takes on empty", rd_word, 32'h0);
      idle(HOLD + 2);

      // R8: thresholds
      thr_sel = 2'b01;
      for (int k = 0; k < 3; k++) wr(1'b1, 1'b0, 16'h4000 + 16'(k), 3'b001);
      chk("R8 below 4", {31'h0, req_n}, 32'h1);
      wr(1'b1, 1'b0, 16'h4003, 3'b001);
      chk("R8 at 4", {31'h0, req_n}, 32'h0);
      thr_sel = 2'b10;
      step();
      chk("R8 below 8", {31'h0, req_n}, 32'h1);
      for (int k = 4; k < 8; k++) wr(1'b1, 1'b0, 16'h4000 + 16'(k), 3'b000);
      chk("R8 at 8", {31'h0, req_n}, 32'h0);
      thr_sel = 2'b11;
      for (int k = 8; k < 12; k++) wr(1'b1, 1'b0, 16'h4000 + 16'(k), 3'b000);
      chk("R8 at 12", {31'h0, req_n}, 32'h0);
      thr_sel = 2'b00;

      // R3: overwrite of oldest
      for (int k = 0; k < 20; k++) wr(1'b1, 1'b0, 16'h5000 + 16'(k), 3'b000);
      chk("R3 oldest dropped", {16'h0, rd_word[15:0]}, 32'h4008);
      chk("R2 full code", {29'h0, rd_word[23:21]}, 32'h7);
      rd(24 * 32);
      chk("R4 empty after full drain", rd_word, 32'h0);
      idle(HOLD + 2);

      // R9: synchronization reset
      wr(1'b1, 1'b0, 16'h6001, 3'b000);
      wr(1'b1, 1'b0, 16'h6002, 3'b000);
      sync_rst = 1'b1; blk_valid = 1'b1;
      step();
      sync_rst = 1'b0; blk_valid = 1'b0;
      chk("R9 cleared", rd_word, 32'h0);
      wr(1'b0, 1'b1, 16'h6003, 3'b000);
      chk("R9 req held before sync", {31'h0, req_n}, 32'h1);
      synced = 1'b1;
      step();
      step();
      chk("R9 req after sync", {31'h0, req_n}, 32'h0);
      rd(3);
      chk("R10 blanking", {31'h0, req_n}, 32'h1);
      idle(HOLD + 1);

      // mixed random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         blk_valid    = ($urandom % 3) == 0;
         synced       = ($urandom % 8) != 0;
         wr_unsync_en = ($urandom % 4) == 0;
         sync_rst     = ($urandom % 300) == 0;
         blk_data     = 16'($urandom);
         blk_err      = 3'($urandom % 7);
         blk_ow_found = 1'($urandom);
         blk_ow_kind  = 3'($urandom);
         blk_ari      = 1'($urandom);
         if (($urandom % 40) == 0) rd_active = !rd_active;
         bit_take     = rd_active && (($urandom % 4) != 0);
         if (i % 500 == 0) thr_sel = 2'($urandom);
         step();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule